// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This unit gives every CPU of a cluster two inter-processor interrupts, called "other" and "self". Each one has a pending bit and a mask bit. Software reaches these bits over a simple register bus that also carries the index of the CPU making the access. One group of registers acts on the accessing CPU itself. A second group consists of per-CPU windows, spaced 128 bytes apart, each of which acts on one named CPU whatever CPU performs the access.

When a CPU handles an interrupt it performs an event read. The unit answers with a 32-bit event word that uses the layout of the hardware interrupt controller: type in bits 23:16 and number in bits 15:0. If the hardware controller already has a pending interrupt for that CPU, it takes the slot and this unit yields. The unit masks every IPI it delivers. Software acknowledges the IPI and then unmasks it once handling is done. Each CPU also gets a level output that is high while it has a pending, unmasked IPI.

Top module: `ipi_unit`

## Requirements
- R1: After reset all pending bits are clear, all mask bits are set, every `ipi_irq` bit is low and `evt_word` is zero.
- R2: A read of address 0x2000 returns the accessing CPU index on `bus_rdata` in the cycle after the request.
- R3: A write to 0x2008 with bit n set (n < NCPU) makes "other" pending at CPU n. Bit 31 of the same write makes "self" pending at the accessing CPU.
- R4: A write of ones to 0x200C clears the accessing CPU's pending bits: bit 0 is "other" and bit 31 is "self". A read of 0x200C returns the pending bits in those two positions.
- R5: A write of ones to 0x2024 sets mask bits and a write of ones to 0x2028 clears mask bits, on the accessing CPU, using the same two bit positions. A read of either address returns the mask.
- R6: For CPU c, the window addresses 0x5008+(c<<7), 0x500C+(c<<7), 0x5024+(c<<7) and 0x5028+(c<<7) set pending, clear pending, set mask and clear mask of CPU c, in that order, using the same two bit positions. This holds whatever CPU performs the access. A window with c >= NCPU, or any other unmapped address, changes nothing.
- R7: `ipi_irq[c]` is high exactly while CPU c has at least one IPI that is both pending and unmasked.
- R8: In the cycle after an event read, `evt_word` holds type 4 in bits 23:16 and number 1 ("other") or 2 ("self") in bits 15:0. It is zero if the requesting CPU has no pending, unmasked IPI.
- R9: When both IPIs of a CPU are pending and unmasked, "other" is reported first.
- R10: Delivering an IPI through an event read sets its mask bit and leaves its pending bit unchanged.
- R11: An event read with `evt_hw_busy` high returns zero and leaves all masks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the accessing CPU |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| evt_req | input | 1 | Event read request |
| evt_cpu | input | CPU_W | CPU performing the event read |
| evt_hw_busy | input | 1 | Hardware controller claims this event read |
| evt_word | output | 32 | Event word, valid the cycle after `evt_req` |
| ipi_irq | output | NCPU | Per-CPU pending-and-unmasked level |

## Verification
The assertions assume that the bus carries at most one access per cycle and that `bus_cpu` and `evt_cpu` stay below NCPU while a request is valid. The stimulus drives requests only from single-cycle tasks, one request per task, with CPU indices in range. The assertions also assume that a set and a clear of the same pending bit never arrive in the same cycle. The stimulus guarantees this because no single register write can do both.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  // Register-window geometry
  localparam int WIN_SHIFT = 7;

  typedef enum logic [2:0] {
    OP_NONE, OP_WHO, OP_SEND, OP_PEND_SET, OP_PEND_CLR, OP_MASK_SET, OP_MASK_CLR
  } ipi_op_e;

  localparam logic [7:0] EVT_KIND_IPI = 8'd4;

  // Bus word <-> {self, other} pair: other in bit 0, self in bit 31
  function automatic logic [1:0] word_to_pair(input logic [31:0] w);
    return {w[31], w[0]};
  endfunction

  function automatic logic [31:0] pair_to_word(input logic [1:0] p);
    return {p[1], 30'd0, p[0]};
  endfunction

  // Priority pick: other before self, one-hot or zero
  function automatic logic [1:0] first_live(input logic [1:0] live);
    if (live[0]) return 2'b01;
    if (live[1]) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] event_word(input logic [1:0] pick);
    if (pick == 2'b01) return {8'd0, EVT_KIND_IPI, 16'd1};
    if (pick == 2'b10) return {8'd0, EVT_KIND_IPI, 16'd2};
    return 32'd0;
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int CPU_W  = 2,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  cpu,
  output ipi_op_e           op,
  output logic [CPU_W-1:0]  tgt
);
  localparam logic [ADDR_W-1:0] LOCAL_BASE = ADDR_W'('h2000);
  localparam logic [ADDR_W-1:0] WIN_BASE   = ADDR_W'('h5000);
  localparam logic [ADDR_W:0]   WIN_END    = (ADDR_W+1)'('h5000 + (NCPU << WIN_SHIFT));

  logic [ADDR_W-1:0] win_off;
  assign win_off = addr - WIN_BASE;

  always_comb begin
    op  = OP_NONE;
    tgt = cpu;
    if (addr == LOCAL_BASE) begin
      op = OP_WHO;
    end else if (addr[ADDR_W-1:8] == LOCAL_BASE[ADDR_W-1:8]) begin
      case (addr[7:0])
        8'h08:   op = OP_SEND;
        8'h0C:   op = OP_PEND_CLR;
        8'h24:   op = OP_MASK_SET;
        8'h28:   op = OP_MASK_CLR;
        default: op = OP_NONE;
      endcase
    end else if (addr >= WIN_BASE && {1'b0, addr} < WIN_END) begin
      tgt = win_off[WIN_SHIFT +: CPU_W];
      case (win_off[WIN_SHIFT-1:0])
        7'h08:   op = OP_PEND_SET;
        7'h0C:   op = OP_PEND_CLR;
        7'h24:   op = OP_MASK_SET;
        7'h28:   op = OP_MASK_CLR;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ipi_cpu_state.sv
module ipi_cpu_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_v,
  input  logic [1:0] clr_v,
  input  logic [1:0] mset_v,
  input  logic [1:0] mclr_v,
  input  logic [1:0] amask_v,
  output logic [1:0] pend,
  output logic [1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 2'b00;
      mask <= 2'b11;
    end else begin
      pend <= (pend & ~clr_v) | set_v;
      mask <= (mask & ~mclr_v) | mset_v | amask_v;
    end
  end

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_v[0] |=> pend[0]);
  // R4
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v[1] && !set_v[1]) |=> !pend[1]);
  // R10
  automask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    amask_v[0] |=> (mask[0] && $stable(pend[0])));
  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mset_v == 2'b00 && mclr_v == 2'b00 && amask_v == 2'b00) |=> $stable(mask));
endmodule

// File: rtl/ipi_event.sv
module ipi_event
  import ipi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       evt_req,
  input  logic [CPU_W-1:0]           evt_cpu,
  input  logic                       evt_hw_busy,
  input  logic [NCPU-1:0][1:0]       live,
  output logic [31:0]                evt_word,
  output logic [NCPU-1:0][1:0]       amask
);
  logic       evt_take;
  logic [1:0] evt_pick;
  logic [1:0] evt_live;

  assign evt_take = evt_req && !evt_hw_busy && (int'(evt_cpu) < NCPU);
  assign evt_live = (int'(evt_cpu) < NCPU) ? live[evt_cpu] : 2'b00;
  assign evt_pick = evt_take ? first_live(evt_live) : 2'b00;

  for (genvar c = 0; c < NCPU; c++) begin : g_amask
    assign amask[c] = (evt_cpu == CPU_W'(c)) ? evt_pick : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       evt_word <= 32'd0;
    else if (evt_req) evt_word <= event_word(evt_pick);
  end

  // R10
  one_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(amask));
  // R11
  hw_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_req && evt_hw_busy) |=> (evt_word == 32'd0));
  // R9
  other_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_take && evt_live == 2'b11) |=> (evt_word[15:0] == 16'd1));
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NCPU   = 4,   // 2..31: send bit 31 is reserved for "self"
  parameter int ADDR_W = 16,
  parameter int CPU_W  = $clog2(NCPU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_req,
  input  logic [CPU_W-1:0]  evt_cpu,
  input  logic              evt_hw_busy,
  output logic [31:0]       evt_word,
  output logic [NCPU-1:0]   ipi_irq
);
  ipi_op_e          op;
  logic [CPU_W-1:0] tgt;
  logic             wr_en;
  logic             rd_en;

  logic [NCPU-1:0][1:0] pend_all, mask_all, live_all, amask_all;

  ipi_decode #(.NCPU(NCPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .cpu(bus_cpu), .op(op), .tgt(tgt)
  );

  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic       hit;
    logic [1:0] set_v, clr_v, mset_v, mclr_v;

    assign hit = wr_en && (tgt == CPU_W'(c));
    assign set_v[0] = wr_en && ((op == OP_SEND && bus_wdata[c]) ||
                                (op == OP_PEND_SET && tgt == CPU_W'(c) && bus_wdata[0]));
    assign set_v[1] = wr_en && ((op == OP_SEND && bus_wdata[31] && bus_cpu == CPU_W'(c)) ||
                                (op == OP_PEND_SET && tgt == CPU_W'(c) && bus_wdata[31]));
    assign clr_v  = (hit && op == OP_PEND_CLR) ? word_to_pair(bus_wdata) : 2'b00;
    assign mset_v = (hit && op == OP_MASK_SET) ? word_to_pair(bus_wdata) : 2'b00;
    assign mclr_v = (hit && op == OP_MASK_CLR) ? word_to_pair(bus_wdata) : 2'b00;

    ipi_cpu_state u_st (
      .clk(clk), .rst_n(rst_n),
      .set_v(set_v), .clr_v(clr_v), .mset_v(mset_v), .mclr_v(mclr_v),
      .amask_v(amask_all[c]),
      .pend(pend_all[c]), .mask(mask_all[c])
    );

    assign live_all[c] = pend_all[c] & ~mask_all[c];
    assign ipi_irq[c]  = |live_all[c];
  end

  ipi_event #(.NCPU(NCPU), .CPU_W(CPU_W)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .evt_req(evt_req), .evt_cpu(evt_cpu), .evt_hw_busy(evt_hw_busy),
    .live(live_all), .evt_word(evt_word), .amask(amask_all)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= 32'd0;
    end else if (rd_en) begin
      case (op)
        OP_WHO:      bus_rdata <= 32'(bus_cpu);
        OP_PEND_CLR: bus_rdata <= pair_to_word(pend_all[tgt]);
        OP_MASK_SET,
        OP_MASK_CLR: bus_rdata <= pair_to_word(mask_all[tgt]);
        default:     bus_rdata <= 32'd0;
      endcase
    end
  end

  // R2
  whoami_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == ADDR_W'('h2000)) |=> (bus_rdata == 32'($past(bus_cpu))));
endmodule

// File: tb/sim_ipi_unit.sv
`timescale 1ns/1ps
module sim_ipi_unit;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_req = 1'b0, evt_hw_busy = 1'b0;
  logic [1:0]  evt_cpu = '0;
  logic [31:0] evt_word;
  logic [NCPU-1:0] ipi_irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ipi_unit #(.NCPU(NCPU), .ADDR_W(16)) u0 (.*);

  // kind: 0 write, 1 read and compare, 2 event read and compare
  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  cpu;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 2'd2, 16'h2000, 32'h0,        32'h2,        4'd2},  // R2 who-am-I
    '{2'd1, 2'd1, 16'h2024, 32'h0,        32'h80000001, 4'd1},  // R1 masks set
    '{2'd0, 2'd0, 16'h2008, 32'h4,        32'h0,        4'd3},
    '{2'd1, 2'd2, 16'h200C, 32'h0,        32'h1,        4'd3},  // R3 other at cpu2
    '{2'd2, 2'd2, 16'h0,    32'h0,        32'h0,        4'd8},  // R8 masked -> none
    '{2'd0, 2'd2, 16'h2028, 32'h80000001, 32'h0,        4'd5},
    '{2'd1, 2'd2, 16'h2024, 32'h0,        32'h0,        4'd5},  // R5 unmasked
    '{2'd0, 2'd2, 16'h2008, 32'h80000000, 32'h0,        4'd3},
    '{2'd1, 2'd2, 16'h200C, 32'h0,        32'h80000001, 4'd3},  // R3 self
    '{2'd2, 2'd2, 16'h0,    32'h0,        32'h00040001, 4'd9},  // R9 other first
    '{2'd1, 2'd2, 16'h2028, 32'h0,        32'h1,        4'd10}, // R10 auto-mask
    '{2'd1, 2'd2, 16'h200C, 32'h0,        32'h80000001, 4'd10}, // R10 pending kept
    '{2'd2, 2'd2, 16'h0,    32'h0,        32'h00040002, 4'd8},  // R8 self number
    '{2'd2, 2'd2, 16'h0,    32'h0,        32'h0,        4'd10}, // R10 both masked
    '{2'd0, 2'd2, 16'h200C, 32'h80000001, 32'h0,        4'd4},
    '{2'd1, 2'd2, 16'h200C, 32'h0,        32'h0,        4'd4},  // R4 acked
    '{2'd0, 2'd0, 16'h5188, 32'h80000000, 32'h0,        4'd6},
    '{2'd1, 2'd1, 16'h518C, 32'h0,        32'h80000000, 4'd6},  // R6 window read
    '{2'd0, 2'd1, 16'h51A8, 32'h80000000, 32'h0,        4'd6},
    '{2'd1, 2'd3, 16'h2024, 32'h0,        32'h1,        4'd6},  // R6 window unmask
    '{2'd2, 2'd3, 16'h0,    32'h0,        32'h00040002, 4'd6},
    '{2'd0, 2'd0, 16'h518C, 32'h80000000, 32'h0,        4'd6},
    '{2'd1, 2'd3, 16'h200C, 32'h0,        32'h0,        4'd6},  // R6 window clear
    '{2'd0, 2'd0, 16'h2010, 32'hFFFFFFFF, 32'h0,        4'd6},  // R6 unmapped write
    '{2'd1, 2'd0, 16'h2024, 32'h0,        32'h80000001, 4'd6}   // R6 nothing changed
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] c, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = c; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] c, input logic [15:0] a, output logic [31:0] r);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = c; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    r = bus_rdata;
  endtask

  task automatic do_ev(input logic [1:0] c, input logic busy, output logic [31:0] r);
    @(negedge clk);
    evt_req = 1'b1; evt_cpu = c; evt_hw_busy = busy;
    @(negedge clk);
    evt_req = 1'b0; evt_hw_busy = 1'b0;
    r = evt_word;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(1, 32'(ipi_irq), 32'h0);
    check(1, evt_word, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].kind)
        2'd0: do_wr(TBL[i].cpu, TBL[i].addr, TBL[i].data);
        2'd1: begin do_rd(TBL[i].cpu, TBL[i].addr, r); check(int'(TBL[i].req), r, TBL[i].exp); end
        default: begin do_ev(TBL[i].cpu, 1'b0, r); check(int'(TBL[i].req), r, TBL[i].exp); end
      endcase
    end

    // R7 level output follows pending and unmasked state
    do_wr(2'd1, 16'h2008, 32'h2);
    check(7, 32'(ipi_irq), 32'h0);
    do_wr(2'd1, 16'h2028, 32'h1);
    check(7, 32'(ipi_irq), 32'h2);
    // R11 hardware controller claims the event read
    do_ev(2'd1, 1'b1, r);
    check(11, r, 32'h0);
    check(11, 32'(ipi_irq), 32'h2);
    do_rd(2'd1, 16'h2024, r);
    check(11, r, 32'h80000000);
    // R10 delivery masks and drops the level
    do_ev(2'd1, 1'b0, r);
    check(8, r, 32'h00040001);
    check(7, 32'(ipi_irq), 32'h0);
    // R5 mask-set write masks again after unmask
    do_wr(2'd1, 16'h2028, 32'h1);
    check(5, 32'(ipi_irq), 32'h2);
    do_wr(2'd1, 16'h2024, 32'h1);
    check(5, 32'(ipi_irq), 32'h0);
    // R3 broadcast send sets "other" on several CPUs at once
    do_wr(2'd3, 16'h2008, 32'h9);
    do_rd(2'd0, 16'h200C, r);
    check(3, r, 32'h1);
    do_rd(2'd3, 16'h200C, r);
    check(3, r, 32'h1);
    // R1 reset clears everything again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_rd(2'd3, 16'h200C, r);
    check(1, r, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule